// File: doc/BRIEF.md
# Converter Power-Down and Calibration Sequencer

This block is the control state machine for a two-channel (I and Q) data converter. It watches a global power-down level, a level that powers down only the Q channel, a one-cycle power-on event and a manual calibration request. From these inputs it decides four things:

- when a calibration runs, and which channels it covers;
- when the converter sleeps or wakes;
- when the data outputs are released from high-impedance;
- when the output data can be trusted again after wake-up.

Calibration length is set by a cycle count on an input, so no calibration arithmetic is modelled. After every entry into normal running, a data-valid flag is held low for a programmable pipeline latency. This masks the stale words left in the conversion pipeline. Each channel keeps its own calibrated flag. The Q flag is kept separately because a calibration run while Q is shut down leaves that channel uncalibrated.

Top module: `adc_pwr_cal_seq`

## Requirements
- R1: After reset, and until a power-on event arrives, every output is low: no channel enabled, outputs high-impedance, nothing busy, nothing valid, no channel calibrated.
- R2: A power-on event with global power-down low starts a calibration of both channels on the next clock. Busy, both calibrate strobes and both enables stay high for exactly `cal_len_i` cycles. A length of 0 behaves as 1.
- R3: A power-on event that arrives while global power-down is high leaves the block powered down with no calibration. The power-on calibration starts on the clock after power-down goes low.
- R4: While running, global power-down high causes, on the next cycle, both enables, the output enable and data-valid to go low. Output enable low means the outputs are high-impedance.
- R5: Q power-down high drops the Q enable in the same cycle and leaves the I enable and the output enable high. No input shuts down the I channel alone.
- R6: Global power-down that rises during a calibration is deferred. Busy and the output enable stay high until the programmed length has elapsed, and then the block powers down.
- R7: While running, a rising edge of the calibration request starts a calibration on the next clock. A request held high does not start another one.
- R8: Request edges that arrive while powered down are discarded, so waking later starts no calibration. Edges that arrive during a calibration neither extend it nor queue a second one.
- R9: A calibration started while Q power-down is high keeps the Q calibrate strobe low and leaves the Q calibrated flag at 0. The flag is still 0 after Q power-down later goes low.
- R10: A channel's calibrated flag is set when a calibration covering it completes. It is cleared on the clock edge at which that channel becomes powered down. I is powered down by global power-down; Q by global or Q power-down.
- R11: Data-valid is low during calibration and while powered down. After each entry into running it stays low for `pipe_lat_i` cycles and then goes high. A latency of 0 makes it high in the first running cycle.
- R12: In the running state, if global power-down and a request edge arrive in the same cycle, power-down wins and the request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pd_all_i | input | 1 | Global power-down level |
| pd_q_i | input | 1 | Q-channel-only power-down level |
| por_i | input | 1 | One-cycle power-applied event |
| cal_req_i | input | 1 | Manual calibration request, rising-edge sensitive |
| cal_len_i | input | CAL_W | Calibration duration in cycles |
| pipe_lat_i | input | LAT_W | Pipeline latency masked after entering running |
| en_i_o | output | 1 | I channel enable |
| en_q_o | output | 1 | Q channel enable |
| cal_i_o | output | 1 | I channel calibrate strobe |
| cal_q_o | output | 1 | Q channel calibrate strobe |
| out_en_o | output | 1 | Data output enable; low means high-impedance |
| data_vld_o | output | 1 | Output data trustworthy |
| cal_busy_o | output | 1 | Calibration in progress |
| calib_ok_i_o | output | 1 | I channel calibrated |
| calib_ok_q_o | output | 1 | Q channel calibrated |

## Verification
The assertions check the cycle-local rules on every clock:

- power-down while running drops the output enable on the next cycle, and no request edge can beat it;
- a pending power-on or a sleeping block never shows busy;
- a started calibration holds busy until its counter reports completion;
- a powered-down channel loses its calibrated flag on the next cycle;
- data-valid is never high during calibration.

Some properties span many cycles or depend on history, and only the bench scenarios show them: the exact calibration and masking lengths, including the zero boundaries; that sleeping discards request edges rather than queuing them; that a deferred power-down completes the run; and that a Q-less calibration leaves Q uncalibrated after Q power-down is released.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_PEND  = 3'd1,
        ST_CAL   = 3'd2,
        ST_RUN   = 3'd3,
        ST_SLEEP = 3'd4
    } seq_st_e;

    localparam int unsigned NCH = 2;
    localparam int unsigned CH_I = 0;
    localparam int unsigned CH_Q = 1;

    typedef struct packed {
        seq_st_e st;
        logic    req_prev;
        logic    cover_q;
    } seq_reg_t;

endpackage

// File: rtl/seq_cal_timer.sv
module seq_cal_timer #(
    parameter int unsigned CAL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             run_i,
    input  logic [CAL_W-1:0] len_i,
    output logic             done_o
);

    logic [CAL_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = (len_i == '0) ? '0 : len_i - 1'b1;
        end else if (run_i && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    assign done_o = run_i && !start_i && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // a loaded count must be honoured: no completion while cycles remain
    assert_cnt_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && len_i > 1 |=> !done_o);

endmodule

// File: rtl/seq_vld_mask.sv
module seq_vld_mask #(
    parameter int unsigned LAT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             run_i,
    input  logic [LAT_W-1:0] lat_i,
    output logic             vld_o
);

    logic [LAT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = lat_i;
        end else if (run_i && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    assign vld_o = run_i && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_mask_entry_R11: assert property (@(posedge clk) disable iff (!rst_n)
        load_i && lat_i != '0 |=> !vld_o);

endmodule

// File: rtl/seq_chan_stat.sv
module seq_chan_stat (
    input  logic clk,
    input  logic rst_n,
    input  logic down_i,
    input  logic done_i,
    input  logic cover_i,
    output logic ok_o
);

    logic ok_q, ok_d;

    always_comb begin
        ok_d = ok_q;
        if (down_i)                ok_d = 1'b0;
        else if (done_i && cover_i) ok_d = 1'b1;
    end

    assign ok_o = ok_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ok_q <= 1'b0;
        else        ok_q <= ok_d;
    end

    assert_down_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        down_i |=> !ok_o);

endmodule

// File: rtl/adc_pwr_cal_seq.sv
module adc_pwr_cal_seq
    import adc_seq_pkg::*;
#(
    parameter int unsigned CAL_W = 16,
    parameter int unsigned LAT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd_all_i,
    input  logic             pd_q_i,
    input  logic             por_i,
    input  logic             cal_req_i,
    input  logic [CAL_W-1:0] cal_len_i,
    input  logic [LAT_W-1:0] pipe_lat_i,
    output logic             en_i_o,
    output logic             en_q_o,
    output logic             cal_i_o,
    output logic             cal_q_o,
    output logic             out_en_o,
    output logic             data_vld_o,
    output logic             cal_busy_o,
    output logic             calib_ok_i_o,
    output logic             calib_ok_q_o
);

    seq_reg_t r_q, r_d;

    logic req_rise;
    logic cal_start;
    logic cal_done;
    logic run_entry;
    logic i_down_d;
    logic [NCH-1:0] ch_down;
    logic [NCH-1:0] ch_cover;
    logic [NCH-1:0] ch_ok;

    assign req_rise = cal_req_i && !r_q.req_prev;

    always_comb begin
        r_d          = r_q;
        r_d.req_prev = cal_req_i;
        unique case (r_q.st)
            ST_OFF: begin
                if (por_i) r_d.st = pd_all_i ? ST_PEND : ST_CAL;
            end
            ST_PEND: begin
                if (!pd_all_i) r_d.st = ST_CAL;
            end
            ST_CAL: begin
                if (cal_done) r_d.st = pd_all_i ? ST_SLEEP : ST_RUN;
            end
            ST_RUN: begin
                if (pd_all_i)      r_d.st = ST_SLEEP;
                else if (req_rise) r_d.st = ST_CAL;
            end
            ST_SLEEP: begin
                if (!pd_all_i) r_d.st = ST_RUN;
            end
            default: r_d.st = ST_OFF;
        endcase
        if (r_d.st == ST_CAL && r_q.st != ST_CAL) begin
            r_d.cover_q = !pd_q_i;
        end
    end

    assign cal_start = (r_d.st == ST_CAL) && (r_q.st != ST_CAL);
    assign run_entry = (r_d.st == ST_RUN) && (r_q.st != ST_RUN);
    assign i_down_d  = (r_d.st == ST_OFF) || (r_d.st == ST_PEND) || (r_d.st == ST_SLEEP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st       <= ST_OFF;
            r_q.req_prev <= 1'b0;
            r_q.cover_q  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    seq_cal_timer #(.CAL_W(CAL_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (cal_start),
        .run_i   (r_q.st == ST_CAL),
        .len_i   (cal_len_i),
        .done_o  (cal_done)
    );

    seq_vld_mask #(.LAT_W(LAT_W)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (run_entry),
        .run_i  (r_q.st == ST_RUN),
        .lat_i  (pipe_lat_i),
        .vld_o  (data_vld_o)
    );

    assign ch_down[CH_I]  = i_down_d;
    assign ch_down[CH_Q]  = i_down_d || pd_q_i;
    assign ch_cover[CH_I] = 1'b1;
    assign ch_cover[CH_Q] = r_q.cover_q;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        seq_chan_stat u_stat (
            .clk     (clk),
            .rst_n   (rst_n),
            .down_i  (ch_down[g]),
            .done_i  (cal_done),
            .cover_i (ch_cover[g]),
            .ok_o    (ch_ok[g])
        );
    end

    assign en_i_o       = (r_q.st == ST_CAL) || (r_q.st == ST_RUN);
    assign en_q_o       = en_i_o && !pd_q_i;
    assign cal_i_o      = (r_q.st == ST_CAL);
    assign cal_q_o      = cal_i_o && r_q.cover_q && !pd_q_i;
    assign out_en_o     = en_i_o;
    assign cal_busy_o   = cal_i_o;
    assign calib_ok_i_o = ch_ok[CH_I];
    assign calib_ok_q_o = ch_ok[CH_Q];

    // ---------------- assertions ----------------
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.st == ST_OFF && !por_i |=> !out_en_o && !cal_busy_o);

    assert_pend_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.st == ST_PEND && pd_all_i |=> !cal_busy_o && !out_en_o);

    assert_pd_hiz_R4: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.st == ST_RUN && pd_all_i |=> !out_en_o && !data_vld_o);

    assert_q_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        en_q_o |-> en_i_o);

    assert_defer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cal_busy_o && !cal_done |=> cal_busy_o && out_en_o);

    assert_edge_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.st == ST_RUN && !pd_all_i && cal_req_i && !r_q.req_prev |=> cal_busy_o);

    assert_sleep_discard_R8: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.st == ST_SLEEP |=> !cal_busy_o);

    assert_q_skip_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cal_busy_o && !r_q.cover_q |-> !calib_ok_q_o);

    assert_no_vld_in_cal_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cal_busy_o |-> !data_vld_o);

    assert_pd_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.st == ST_RUN && pd_all_i && req_rise |=> !cal_busy_o);

endmodule

// File: tb/sim_adc_pwr_cal_seq.sv
`timescale 1ns/1ps
module sim_adc_pwr_cal_seq;

    localparam int CAL_W = 16;
    localparam int LAT_W = 6;

    // output vector bit positions {en_i,en_q,cal_i,cal_q,oe,vld,busy,ok_i,ok_q}
    localparam logic [8:0] EI = 9'h100, EQ = 9'h080, CI = 9'h040, CQ = 9'h020,
                           OE = 9'h010, VL = 9'h008, BZ = 9'h004, KI = 9'h002, KQ = 9'h001;
    localparam logic [8:0] CAL2 = EI | EQ | CI | CQ | OE | BZ;
    localparam logic [8:0] RUN2 = EI | EQ | OE;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pd_all = 1'b0, pd_q = 1'b0, por = 1'b0, req = 1'b0;
    logic [CAL_W-1:0] cal_len = 16'd4;
    logic [LAT_W-1:0] lat = 6'd3;
    logic en_i, en_q, cal_i, cal_q, oe, vld, busy, ok_i, ok_q;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        logic [8:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;

    adc_pwr_cal_seq #(.CAL_W(CAL_W), .LAT_W(LAT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .pd_all_i(pd_all), .pd_q_i(pd_q), .por_i(por),
        .cal_req_i(req), .cal_len_i(cal_len), .pipe_lat_i(lat),
        .en_i_o(en_i), .en_q_o(en_q), .cal_i_o(cal_i), .cal_q_o(cal_q),
        .out_en_o(oe), .data_vld_o(vld), .cal_busy_o(busy),
        .calib_ok_i_o(ok_i), .calib_ok_q_o(ok_q)
    );

    // monitor: one expectation per clock, compared just after the edge
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            item_t it;
            logic [8:0] act;
            it  = sb.pop_front();
            act = {en_i, en_q, cal_i, cal_q, oe, vld, busy, ok_i, ok_q};
            n_run++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: got %b expected %b", it.tag, act, it.exp);
            end
        end
    end

    // driver: set inputs for the coming edge and queue the expected outputs
    task automatic cyc(input logic p, input logic pq, input logic po, input logic rq,
                       input logic [8:0] e, input string tag);
        @(negedge clk);
        pd_all = p; pd_q = pq; por = po; req = rq;
        sb.push_back('{exp: e, tag: tag});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; pd_all = 0; pd_q = 0; por = 0; req = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: quiet before power-on
        cyc(0, 0, 0, 0, 9'h000, "R1");
        cyc(0, 0, 0, 0, 9'h000, "R1");
        // R2: power-on calibration of both channels, 4 cycles
        cyc(0, 0, 1, 0, CAL2, "R2");
        repeat (3) cyc(0, 0, 0, 0, CAL2, "R2");
        // R11: valid masked 3 cycles, R10 both flags set
        repeat (3) cyc(0, 0, 0, 0, RUN2 | KI | KQ, "R11");
        repeat (2) cyc(0, 0, 0, 0, RUN2 | KI | KQ | VL, "R11");
        // R7: edge starts calibration; held level does not retrigger
        repeat (4) cyc(0, 0, 0, 1, CAL2 | KI | KQ, "R7");
        repeat (3) cyc(0, 0, 0, 1, RUN2 | KI | KQ, "R7");
        cyc(0, 0, 0, 1, RUN2 | KI | KQ | VL, "R7");
        cyc(0, 0, 0, 0, RUN2 | KI | KQ | VL, "R7");
        // R8: edges during calibration ignored
        cyc(0, 0, 0, 1, CAL2 | KI | KQ, "R8");
        cyc(0, 0, 0, 0, CAL2 | KI | KQ, "R8");
        cyc(0, 0, 0, 1, CAL2 | KI | KQ, "R8");
        cyc(0, 0, 0, 0, CAL2 | KI | KQ, "R8");
        repeat (3) cyc(0, 0, 0, 0, RUN2 | KI | KQ, "R8");
        cyc(0, 0, 0, 0, RUN2 | KI | KQ | VL, "R8");
        // R4 / R10: power-down goes high-impedance and clears flags
        cyc(1, 0, 0, 0, 9'h000, "R4");
        // R8: request edges in power-down discarded
        cyc(1, 0, 0, 1, 9'h000, "R8");
        cyc(1, 0, 0, 0, 9'h000, "R8");
        cyc(1, 0, 0, 1, 9'h000, "R8");
        repeat (3) cyc(0, 0, 0, 1, RUN2, "R8");
        cyc(0, 0, 0, 1, RUN2 | VL, "R8");
        cyc(0, 0, 0, 0, RUN2 | VL, "R8");
        // R5: Q-only power-down
        cyc(0, 1, 0, 0, EI | OE | VL, "R5");
        // R9: calibration with Q down covers I only
        repeat (4) cyc(0, 1, 0, 1, EI | CI | OE | BZ, "R9");
        repeat (3) cyc(0, 1, 0, 0, EI | OE | KI, "R9");
        cyc(0, 1, 0, 0, EI | OE | KI | VL, "R9");
        cyc(0, 0, 0, 0, RUN2 | KI | VL, "R9");
        // R6: power-down deferred until calibration ends
        cyc(0, 0, 0, 1, CAL2 | KI, "R6");
        repeat (3) cyc(1, 0, 0, 0, CAL2 | KI, "R6");
        cyc(1, 0, 0, 0, 9'h000, "R6");
        repeat (3) cyc(0, 0, 0, 0, RUN2, "R11");
        cyc(0, 0, 0, 0, RUN2 | VL, "R11");
        // R12: power-down beats a same-cycle request edge
        cyc(1, 0, 0, 1, 9'h000, "R12");
        cyc(0, 0, 0, 1, RUN2, "R12");
        cyc(0, 0, 0, 0, RUN2, "R12");
        // R3: power-on while powered down waits for release
        do_reset();
        cyc(1, 0, 1, 0, 9'h000, "R3");
        repeat (3) cyc(1, 0, 0, 0, 9'h000, "R3");
        repeat (4) cyc(0, 0, 0, 0, CAL2, "R3");
        cyc(0, 0, 0, 0, RUN2 | KI | KQ, "R3");
        // R2 / R11 boundaries: length 0 acts as 1, latency 0 gives immediate valid
        @(negedge clk);
        cal_len = '0; lat = '0;
        cyc(0, 0, 0, 1, CAL2 | KI | KQ, "R2");
        cyc(0, 0, 0, 0, RUN2 | KI | KQ | VL, "R11");
        cyc(0, 0, 0, 0, RUN2 | KI | KQ | VL, "R11");
        @(posedge clk);
        #2;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule